// File: doc/BRIEF.md
# Six-Channel Complementary PWM Output Stage

This block turns six raw PWM generator signals into the six final pin levels of a motor-drive or power-stage timer. A mode input chooses how channels are arranged: each channel follows its own generator, the odd channel of every pair runs as the inverse of its even partner, or the odd channel copies its even partner. A group input lets every even channel follow channel 0, so all pairs switch in phase. In the inverted-pair arrangement, each pair can insert a shared dead-time. The dead-time holds back every rising edge so the two switches of a half bridge are never driven on together.

After the arrangement and dead-time stages, each channel passes through three overrides in a fixed order. A software mask is applied first, then the brake level, then output polarity. The brake-active condition comes from outside the block. Pin levels are registered once. Channels 0, 2 and 4 also feed edge detectors. Each detector sets a sticky flag on a selectable edge, and any enabled flag raises a shared interrupt line.

Top module: `pwm_out_stage`

## Requirements
- R1: With mode 2'b00 (independent), or the unused code 2'b11, every channel n drives pin n from raw bit n.
- R2: With mode 2'b01 (inverted pairs), channels 2p+1 output the inverse of channel 2p, and raw odd bits are ignored.
- R3: With mode 2'b10 (synchronized), channels 2p+1 output the same level as channel 2p, without inversion.
- R4: With the group input high, channels 2 and 4 take raw bit 0 instead of their own raw bits, in every mode.
- R5: In mode 2'b01 with a pair's dead-time enable set (enable bit p for pair 2p/2p+1), each rising edge on either output of the pair is delayed by dead_count clock cycles. Falling edges are not delayed.
- R6: With dead-time active, a high pulse shorter than dead_count cycles never appears on the output.
- R7: Dead-time acts only on pairs whose enable bit is set, and only in mode 2'b01. Otherwise the pair switches with no added delay.
- R8: When mask_en bit n is set, channel n is replaced by mask_data bit n.
- R9: While brake_active is high, channel n takes brake_level bit n, overriding the mask.
- R10: Polarity bit n inverts channel n last, after the mask and brake stages.
- R11: The edge flag for channel 0, 2 or 4 (flag bits 0, 1, 2) sets on a rising pin edge when its edge_type bit is 1, and on a falling pin edge when it is 0. The flag is high one cycle after the pin changes.
- R12: A pulse on edge_clr bit i clears flag i, unless a new edge arrives in the same cycle.
- R13: edge_irq is high exactly when some flag bit i and edge_irq_en bit i are both high.
- R14: Pins change one clock after their inputs change. During reset all pins and flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Channel arrangement: 00 independent, 01 inverted pairs, 10 synchronized, 11 as 00 |
| group_en | input | 1 | Even channels follow channel 0 |
| raw_ch | input | 6 | Raw generator signals |
| dead_count | input | 11 | Dead-time length in clock cycles |
| dead_en | input | 3 | Per-pair dead-time enable |
| mask_en | input | 6 | Per-channel mask enable |
| mask_data | input | 6 | Per-channel mask level |
| brake_active | input | 1 | Brake condition |
| brake_level | input | 6 | Per-channel level during brake |
| polarity | input | 6 | Per-channel active-low select |
| edge_type | input | 3 | Edge select for channels 0, 2, 4 (1 rising, 0 falling) |
| edge_clr | input | 3 | Write-one clear pulses for the flags |
| edge_irq_en | input | 3 | Per-flag interrupt enable |
| pin_out | output | 6 | Final pin levels |
| edge_flag | output | 3 | Sticky edge flags for channels 0, 2, 4 |
| edge_irq | output | 1 | Combined edge interrupt |

## Verification
The arrangement logic is driven with raw patterns where the odd bits disagree with what the mode would derive. This shows whether odd channels are being taken from raw bits, inverted, or copied. Group tests set channel 0 against channels 2 and 4, which exposes whether the even channels follow channel 0.

The override chain is tried with mask and brake asserted together and with brake and polarity asserted together, so any reordering of the stages changes the pins. Dead-time is tested in four cases: one enabled pair and one disabled pair switching at the same time, a pulse shorter than the count, and a rising edge in each direction of the pair. It is also tried with enables set in independent mode. Edge flags are checked for the selected edge, the opposite edge, clearing, and interrupt gating.

// File: rtl/pwm_out_pkg.sv
// Shared types for the PWM output stage.
package pwm_out_pkg;
    typedef enum logic [1:0] {
        MODE_INDEP = 2'b00,
        MODE_COMP  = 2'b01,
        MODE_SYNC  = 2'b10,
        MODE_RSVD  = 2'b11
    } pwm_mode_e;
endpackage

// File: rtl/pwm_arrange.sv
// Channel arrangement: applies grouping and derives odd channels from the
// selected mode. Purely combinational; assumes 2*NUM_PAIRS channels with
// channel 0 as the group leader.
module pwm_arrange
    import pwm_out_pkg::*;
#(
    parameter int NUM_PAIRS = 3,
    localparam int NCH = 2 * NUM_PAIRS
) (
    input  pwm_mode_e          mode,
    input  logic               group_en,
    input  logic [NCH-1:0]     raw_ch,
    output logic [NCH-1:0]     arr_ch
);
    // Build each pair's even and odd level from mode and group setting.
    always_comb begin
        for (int p = 0; p < NUM_PAIRS; p++) begin
            arr_ch[2*p] = (group_en && p != 0) ? raw_ch[0] : raw_ch[2*p];
            case (mode)
                MODE_COMP: arr_ch[2*p+1] = ~arr_ch[2*p];
                MODE_SYNC: arr_ch[2*p+1] =  arr_ch[2*p];
                default:   arr_ch[2*p+1] =  raw_ch[2*p+1];
            endcase
        end
    end
endmodule

// File: rtl/pwm_deadtime.sv
// Dead-time inserter for one pair: each output rises only after its input
// has been high for dead_count cycles; falls pass at once. When en is low
// the inputs pass straight through. Assumes inputs are complementary
// whenever en is high.
module pwm_deadtime #(
    parameter int DT_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [DT_W-1:0] dead_count,
    input  logic [1:0]      sig_in,
    output logic [1:0]      sig_out
);
    logic [DT_W-1:0] hold_q [2];

    for (genvar s = 0; s < 2; s++) begin : g_sig
        // Count cycles the input has stayed high, saturating at dead_count.
        always_ff @(posedge clk) begin
            if (!rst_n)
                hold_q[s] <= '0;
            else if (!sig_in[s])
                hold_q[s] <= '0;
            else if (hold_q[s] < dead_count)
                hold_q[s] <= hold_q[s] + 1'b1;
        end

        // Gate the rising edge until the hold count is reached.
        assign sig_out[s] = en ? (sig_in[s] && (hold_q[s] >= dead_count))
                               : sig_in[s];

        // R6: with a nonzero count an output can only rise after a high input cycle
        a_r6_rise_after_high: assert property (@(posedge clk) disable iff (!rst_n)
            (en && dead_count != '0 && $rose(sig_out[s])) |-> $past(sig_in[s]))
            else $error("dead-time output rose without prior high input");
    end

    // R5: complementary inputs never yield both outputs high
    a_r5_pair_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (sig_in[0] ^ sig_in[1])) |-> !(sig_out[0] && sig_out[1]))
        else $error("both outputs of a pair high under dead-time");
endmodule

// File: rtl/pwm_override.sv
// Per-channel override chain: mask, then brake level, then polarity.
// Purely combinational; assumes the brake condition is already conditioned.
module pwm_override #(
    parameter int NCH = 6
) (
    input  logic [NCH-1:0] ch_in,
    input  logic [NCH-1:0] mask_en,
    input  logic [NCH-1:0] mask_data,
    input  logic           brake_active,
    input  logic [NCH-1:0] brake_level,
    input  logic [NCH-1:0] polarity,
    output logic [NCH-1:0] ch_out
);
    logic [NCH-1:0] masked;
    logic [NCH-1:0] braked;

    // Apply the three overrides in fixed order for every channel.
    always_comb begin
        for (int n = 0; n < NCH; n++) begin
            masked[n] = mask_en[n] ? mask_data[n] : ch_in[n];
            braked[n] = brake_active ? brake_level[n] : masked[n];
            ch_out[n] = braked[n] ^ polarity[n];
        end
    end
endmodule

// File: rtl/pwm_edge_flags.sv
// Sticky edge flags on the even pins with selectable edge and write-one
// clear; a new edge wins over a clear in the same cycle. Assumes pins are
// registered outputs.
module pwm_edge_flags #(
    parameter int NE = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NE-1:0] pin_even,
    input  logic [NE-1:0] edge_type,
    input  logic [NE-1:0] edge_clr,
    input  logic [NE-1:0] edge_irq_en,
    output logic [NE-1:0] edge_flag,
    output logic          edge_irq
);
    logic [NE-1:0] prev_q;
    logic [NE-1:0] hit;

    // Remember the last pin level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pin_even;
    end

    // Detect the selected edge on each watched pin.
    always_comb begin
        for (int i = 0; i < NE; i++)
            hit[i] = edge_type[i] ? (pin_even[i] && !prev_q[i])
                                  : (!pin_even[i] && prev_q[i]);
    end

    // Set on edge, clear on write-one, edge taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) edge_flag <= '0;
        else        edge_flag <= (edge_flag & ~edge_clr) | hit;
    end

    assign edge_irq = |(edge_flag & edge_irq_en);

    for (genvar i = 0; i < NE; i++) begin : g_chk
        // R12: a clear with no coincident edge drops the flag
        a_r12_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_clr[i] && (pin_even[i] == prev_q[i])) |=> !edge_flag[i])
            else $error("edge flag survived a clear");
    end
endmodule

// File: rtl/pwm_out_stage.sv
// Top of the PWM output stage: arrangement, per-pair dead-time, override
// chain and one output register, plus edge flags on even pins. Assumes
// brake_active is synchronous to clk.
module pwm_out_stage
    import pwm_out_pkg::*;
#(
    parameter int NUM_PAIRS = 3,
    parameter int DT_W      = 11,
    localparam int NCH      = 2 * NUM_PAIRS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode,
    input  logic                 group_en,
    input  logic [NCH-1:0]       raw_ch,
    input  logic [DT_W-1:0]      dead_count,
    input  logic [NUM_PAIRS-1:0] dead_en,
    input  logic [NCH-1:0]       mask_en,
    input  logic [NCH-1:0]       mask_data,
    input  logic                 brake_active,
    input  logic [NCH-1:0]       brake_level,
    input  logic [NCH-1:0]       polarity,
    input  logic [NUM_PAIRS-1:0] edge_type,
    input  logic [NUM_PAIRS-1:0] edge_clr,
    input  logic [NUM_PAIRS-1:0] edge_irq_en,
    output logic [NCH-1:0]       pin_out,
    output logic [NUM_PAIRS-1:0] edge_flag,
    output logic                 edge_irq
);
    pwm_mode_e            mode_e;
    logic [NCH-1:0]       arr_ch;
    logic [NCH-1:0]       dt_ch;
    logic [NCH-1:0]       pin_d;
    logic [NUM_PAIRS-1:0] pin_even;

    assign mode_e = pwm_mode_e'(mode);

    pwm_arrange #(.NUM_PAIRS(NUM_PAIRS)) arrange_i (
        .mode     (mode_e),
        .group_en (group_en),
        .raw_ch   (raw_ch),
        .arr_ch   (arr_ch)
    );

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        logic dt_act;
        assign dt_act = dead_en[p] && (mode_e == MODE_COMP);

        pwm_deadtime #(.DT_W(DT_W)) dt_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .en         (dt_act),
            .dead_count (dead_count),
            .sig_in     (arr_ch[2*p+1:2*p]),
            .sig_out    (dt_ch[2*p+1:2*p])
        );

        assign pin_even[p] = pin_out[2*p];
    end

    pwm_override #(.NCH(NCH)) override_i (
        .ch_in        (dt_ch),
        .mask_en      (mask_en),
        .mask_data    (mask_data),
        .brake_active (brake_active),
        .brake_level  (brake_level),
        .polarity     (polarity),
        .ch_out       (pin_d)
    );

    // Register the final pin levels.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_out <= '0;
        else        pin_out <= pin_d;
    end

    pwm_edge_flags #(.NE(NUM_PAIRS)) edges_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_even    (pin_even),
        .edge_type   (edge_type),
        .edge_clr    (edge_clr),
        .edge_irq_en (edge_irq_en),
        .edge_flag   (edge_flag),
        .edge_irq    (edge_irq)
    );

    // R9: a brake cycle drives brake level through polarity on the next clock
    a_r9_brake_level: assert property (@(posedge clk) disable iff (!rst_n)
        brake_active |=> (pin_out == $past(brake_level ^ polarity)))
        else $error("brake level not at pins");

    // R11: a flag on channel 0 rises only after its pin changed
    a_r11_flag_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(edge_flag[0]) |-> ($past(pin_out[0]) != $past(pin_out[0], 2)))
        else $error("edge flag set without a pin edge");
endmodule

// File: tb/pwm_out_stage_tb_top.sv
module pwm_out_stage_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = '0;
    logic        group_en = 1'b0;
    logic [5:0]  raw_ch = '0;
    logic [10:0] dead_count = '0;
    logic [2:0]  dead_en = '0;
    logic [5:0]  mask_en = '0, mask_data = '0;
    logic        brake_active = 1'b0;
    logic [5:0]  brake_level = '0, polarity = '0;
    logic [2:0]  edge_type = '0, edge_clr = '0, edge_irq_en = '0;
    logic [5:0]  pin_out;
    logic [2:0]  edge_flag;
    logic        edge_irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pwm_out_stage dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .group_en(group_en),
        .raw_ch(raw_ch), .dead_count(dead_count), .dead_en(dead_en),
        .mask_en(mask_en), .mask_data(mask_data), .brake_active(brake_active),
        .brake_level(brake_level), .polarity(polarity), .edge_type(edge_type),
        .edge_clr(edge_clr), .edge_irq_en(edge_irq_en), .pin_out(pin_out),
        .edge_flag(edge_flag), .edge_irq(edge_irq)
    );

    typedef struct packed {
        logic [1:0] md;
        logic       grp;
        logic [5:0] raw;
        logic [5:0] men;
        logic [5:0] mdat;
        logic       brk;
        logic [5:0] blev;
        logic [5:0] pol;
        logic [5:0] exp_pin;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 1'b0, 6'b101010, 6'h00, 6'h00, 1'b0, 6'h00, 6'h00, 6'b101010},
        '{2'b01, 1'b0, 6'b101111, 6'h00, 6'h00, 1'b0, 6'h00, 6'h00, 6'b100101},
        '{2'b10, 1'b0, 6'b010001, 6'h00, 6'h00, 1'b0, 6'h00, 6'h00, 6'b110011},
        '{2'b10, 1'b1, 6'b000001, 6'h00, 6'h00, 1'b0, 6'h00, 6'h00, 6'b111111},
        '{2'b01, 1'b1, 6'b010100, 6'h00, 6'h00, 1'b0, 6'h00, 6'h00, 6'b101010},
        '{2'b00, 1'b1, 6'b000001, 6'h00, 6'h00, 1'b0, 6'h00, 6'h00, 6'b010101},
        '{2'b00, 1'b0, 6'b111111, 6'b000011, 6'b000001, 1'b0, 6'h00, 6'h00, 6'b111101},
        '{2'b00, 1'b0, 6'b111111, 6'h00, 6'h00, 1'b1, 6'b001100, 6'h00, 6'b001100},
        '{2'b00, 1'b0, 6'b111111, 6'b111111, 6'b111111, 1'b1, 6'h00, 6'h00, 6'h00},
        '{2'b00, 1'b0, 6'b000011, 6'h00, 6'h00, 1'b0, 6'h00, 6'b001111, 6'b001100},
        '{2'b00, 1'b0, 6'b000000, 6'h00, 6'h00, 1'b1, 6'b110000, 6'b100001, 6'b010001},
        '{2'b11, 1'b0, 6'b100110, 6'h00, 6'h00, 1'b0, 6'h00, 6'h00, 6'b100110}
    };

    function automatic string vec_req(int i);
        case (i)
            0: return "R1";  1: return "R2";  2: return "R3";
            3: return "R4";  4: return "R4";  5: return "R4";
            6: return "R8";  7: return "R9";  8: return "R9";
            9: return "R10"; 10: return "R10"; default: return "R1";
        endcase
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Advance n rising edges and settle away from the edge.
    task automatic step(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R14: reset state
        raw_ch = 6'h3f;
        step(3);
        chk("R14 reset pins", pin_out, 0);
        chk("R14 reset flags", edge_flag, 0);
        rst_n = 1'b1;
        raw_ch = '0;
        step(2);

        // Table walk with dead-time off
        for (int i = 0; i < NV; i++) begin
            mode = VECS[i].md;  group_en = VECS[i].grp;  raw_ch = VECS[i].raw;
            mask_en = VECS[i].men;  mask_data = VECS[i].mdat;
            brake_active = VECS[i].brk;  brake_level = VECS[i].blev;
            polarity = VECS[i].pol;
            step(1);
            chk(vec_req(i), pin_out, VECS[i].exp_pin);
        end
        mode = 2'b00; group_en = 0; mask_en = 0; mask_data = 0;
        brake_active = 0; brake_level = 0; polarity = 0; raw_ch = 0;
        step(2);

        // R14: one-cycle latency
        raw_ch = 6'h3f;
        #1;
        chk("R14 before edge", pin_out, 0);
        step(1);
        chk("R14 after edge", pin_out, 6'h3f);

        // Dead-time on pair 0 only
        raw_ch = 0; mode = 2'b01; dead_count = 11'd3; dead_en = 3'b001;
        step(6);
        chk("R2 settled pair0", pin_out[1:0], 2'b10);
        raw_ch = 6'b000101;
        step(1);
        chk("R5 dead band start", pin_out[1:0], 2'b00);
        chk("R7 pair1 no delay", pin_out[3:2], 2'b01);
        step(2);
        chk("R5 still in dead band", pin_out[1:0], 2'b00);
        step(1);
        chk("R5 even rises", pin_out[1:0], 2'b01);
        raw_ch = 0;
        step(1);
        chk("R5 odd delayed", pin_out[1:0], 2'b00);
        step(3);
        chk("R5 odd rises", pin_out[1:0], 2'b10);

        // R6: short pulse suppressed
        raw_ch[0] = 1'b1;
        begin
            int hi_seen = 0;
            for (int c = 0; c < 6; c++) begin
                if (c == 2) raw_ch[0] = 1'b0;
                step(1);
                if (pin_out[0]) hi_seen++;
            end
            chk("R6 short pulse", hi_seen, 0);
        end

        // R7: enables ignored outside inverted-pair mode
        mode = 2'b00; dead_en = 3'b111; raw_ch = 0;
        step(2);
        raw_ch = 6'b000001;
        step(1);
        chk("R7 independent no delay", pin_out[0], 1);

        // Edge flags
        dead_en = 0; raw_ch = 0;
        step(2);
        edge_clr = 3'b111; step(1); edge_clr = 0;
        edge_type = 3'b001; edge_irq_en = 0;
        raw_ch = 6'b000001;
        step(1);
        chk("R11 flag lags pin", edge_flag[0], 0);
        step(1);
        chk("R11 rising flag", edge_flag[0], 1);
        chk("R13 irq masked", edge_irq, 0);
        edge_irq_en = 3'b001;
        #1;
        chk("R13 irq enabled", edge_irq, 1);
        edge_clr = 3'b001; step(1); edge_clr = 0;
        chk("R12 cleared", edge_flag[0], 0);
        raw_ch = 0;
        step(3);
        chk("R11 falling ignored", edge_flag[0], 0);
        raw_ch = 6'b000100;
        step(3);
        edge_clr = 3'b111; step(1); edge_clr = 0;
        raw_ch = 0;
        step(3);
        chk("R11 falling on ch2", edge_flag, 3'b010);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule